// File: doc/BRIEF.md
# Byte-Serial Host Register Port for a Two-Axis Counter

This block is the host-side register port of a two-axis position counter. A host uses an 8-bit data bus with a chip select, separate read and write strobes, a control/data qualifier and an axis select. There are no address lines. On a control write, the top three bits of the written byte choose the destination. Two of these bits pick one of four per-axis registers, and one bit sends the write to both axes. On a data access, the 24-bit preset value (written) or the 24-bit output latch (read) is reached one byte at a time. Each axis has its own byte pointer, and that pointer steps after every data strobe.

The block holds the presets, the byte pointers and the three plain configuration registers (mode, I/O and index) for each axis. A write to the command register produces one-cycle command pulses toward the counter logic of each axis. The counter logic is outside this block and supplies the output-latch values and the status bytes.

All strobes are sampled synchronously to `clk` and are active high. An access takes effect in the clock after the strobe is seen to fall. The bus has no back-pressure and no valid/ready pair: every strobe that is qualified by the select is accepted and completes. Read data is driven combinationally while the read strobe and the select are both high. `bus_dout_oe` marks the cycles in which the data is driven.

Top module: `hbi_top`

## Requirements
- R1: While `bus_sel` is low, strobes have no effect. No preset, register, byte pointer or command output changes, and `bus_dout_oe` stays low.
- R2: A control write with byte bits 6:5 = 01 stores bits 4:0 in the mode register. With 10 it stores them in the I/O register, and with 11 in the index register. The other registers keep their values.
- R3: A control write with bit 7 = 1 acts on both axes whatever `bus_axis` is. With bit 7 = 0 it acts only on the axis given by `bus_axis` (0 = X, 1 = Y).
- R4: A data write stores the byte into the preset byte that the selected axis' pointer addresses. Pointer 0 is bits 7:0, pointer 1 is bits 15:8 and pointer 2 is bits 23:16.
- R5: During a data read, `bus_dout` shows the output-latch byte of the selected axis at that axis' pointer, using the same byte order as R4.
- R6: During a control read, `bus_dout` shows the status byte of the selected axis. The pointer does not move.
- R7: The selected axis' pointer advances one step in the clock after a data strobe falls. After the third byte it wraps from 2 back to 0.
- R8: A command-register write (bits 6:5 = 00) with bit 0 = 1 clears the pointer of each targeted axis to 0.
- R9: In a command-register write, bits 2:1 give a one-cycle pulse in the clock after the strobe falls. 01 pulses counter-clear, 10 pulses flag-clear, 11 pulses error-clear and 00 gives no pulse.
- R10: In a command-register write, bits 4:3 give a one-cycle pulse with the same timing as R9. 01 pulses preset-to-counter, 10 pulses counter-to-latch, 11 pulses preset-low-byte-to-prescaler and 00 gives no pulse.
- R11: `bus_dout_oe` is high exactly while `bus_sel` and `bus_rd` are both high.
- R12: After reset, all presets, registers and pointers are zero and no command pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_ctl | input | 1 | 1 = control access, 0 = data access |
| bus_axis | input | 1 | Axis select, 0 = X, 1 = Y |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data |
| bus_dout_oe | output | 1 | Read data drive enable |
| latch_val | input | 48 | Output latches; X in bits 23:0, Y in bits 47:24 |
| status_in | input | 16 | Status bytes; X in bits 7:0, Y in bits 15:8 |
| preset_val | output | 48 | Presets; X in bits 23:0, Y in bits 47:24 |
| mode_reg | output | 10 | Mode fields; X in bits 4:0, Y in bits 9:5 |
| io_reg | output | 10 | I/O fields; same layout |
| index_reg | output | 10 | Index fields; same layout |
| cmd_clr_cnt | output | 2 | Counter-clear pulse, bit per axis |
| cmd_clr_flags | output | 2 | Flag-clear pulse, bit per axis |
| cmd_clr_err | output | 2 | Error-clear pulse, bit per axis |
| cmd_load_cnt | output | 2 | Preset-to-counter pulse, bit per axis |
| cmd_latch_cnt | output | 2 | Counter-to-latch pulse, bit per axis |
| cmd_load_psc | output | 2 | Preset-low-byte-to-prescaler pulse, bit per axis |

## Verification
The assertions watch four things on every cycle. Pointers stay in range, and a pointer moves only on a data strobe or a command clear. Presets and configuration fields hold whenever no matching write completes. At most one pulse in each command group is active, and a pulse appears only after a falling write strobe. The bench scenarios cover the rest. They check the byte-order mapping, the wrap of the pointer, and the broadcast and axis-select decode. They also confirm that a deselected strobe leaves every output alone. To do this, the bench sweeps all 256 control bytes on both axis selects and compares against a model of both axes' registers and pointers.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    TGT_CMD   = 2'd0,
    TGT_MODE  = 2'd1,
    TGT_IO    = 2'd2,
    TGT_INDEX = 2'd3
  } hbi_tgt_e;

  typedef struct packed {
    logic clr_cnt;
    logic clr_flags;
    logic clr_err;
    logic load_cnt;
    logic latch_cnt;
    logic load_psc;
  } hbi_cmd_t;
endpackage

// File: rtl/hbi_strobe.sv
module hbi_strobe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic              ctl,
  input  logic              axis,
  input  logic [DATA_W-1:0] din,
  output logic              wr_done,
  output logic              rd_done,
  output logic              cap_ctl,
  output logic              cap_axis,
  output logic [DATA_W-1:0] cap_din
);
  logic wr_q, rd_q;
  logic wr_live, rd_live;

  assign wr_live = sel & wr;
  assign rd_live = sel & rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      cap_ctl  <= 1'b0;
      cap_axis <= 1'b0;
      cap_din  <= '0;
    end else begin
      wr_q <= wr_live;
      rd_q <= rd_live;
      if (wr_live | rd_live) begin
        cap_ctl  <= ctl;
        cap_axis <= axis;
        cap_din  <= din;
      end
    end
  end

  assign wr_done = wr_q & ~wr_live;
  assign rd_done = rd_q & ~rd_live;

  // a completed access must have been qualified by the select one cycle earlier
  assert_done_needs_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done | rd_done) |-> $past(sel));
endmodule

// File: rtl/hbi_axis.sv
module hbi_axis
  import hbi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NBYTES  = 3,
  parameter int FIELD_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_wr,
  input  logic                     data_wr,
  input  logic                     data_rd,
  input  logic [DATA_W-1:0]        byte_in,
  output logic [DATA_W*NBYTES-1:0] preset,
  output logic [((NBYTES>1)?$clog2(NBYTES):1)-1:0] ptr,
  output logic [FIELD_W-1:0]       mode_f,
  output logic [FIELD_W-1:0]       io_f,
  output logic [FIELD_W-1:0]       idx_f,
  output hbi_cmd_t                 cmd
);
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);

  hbi_tgt_e tgt;
  logic     cmd_hit;
  logic [1:0] clr_fld, xfer_fld;

  assign tgt      = hbi_tgt_e'(byte_in[6:5]);
  assign cmd_hit  = ctl_wr & (tgt == TGT_CMD);
  assign clr_fld  = byte_in[2:1];
  assign xfer_fld = byte_in[4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset <= '0;
      ptr    <= '0;
      mode_f <= '0;
      io_f   <= '0;
      idx_f  <= '0;
      cmd    <= '0;
    end else begin
      cmd <= '0;
      if (cmd_hit) begin
        cmd.clr_cnt   <= (clr_fld == 2'd1);
        cmd.clr_flags <= (clr_fld == 2'd2);
        cmd.clr_err   <= (clr_fld == 2'd3);
        cmd.load_cnt  <= (xfer_fld == 2'd1);
        cmd.latch_cnt <= (xfer_fld == 2'd2);
        cmd.load_psc  <= (xfer_fld == 2'd3);
      end
      if (ctl_wr && tgt == TGT_MODE)  mode_f <= byte_in[FIELD_W-1:0];
      if (ctl_wr && tgt == TGT_IO)    io_f   <= byte_in[FIELD_W-1:0];
      if (ctl_wr && tgt == TGT_INDEX) idx_f  <= byte_in[FIELD_W-1:0];
      if (data_wr) preset[ptr*DATA_W +: DATA_W] <= byte_in;
      if (cmd_hit && byte_in[0]) ptr <= '0;
      else if (data_wr | data_rd) ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end

  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_LAST);
  assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr | data_rd | cmd_hit) |=> $stable(ptr));
  assert_preset_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(preset));
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ($stable(mode_f) && $stable(io_f) && $stable(idx_f)));
  assert_clr_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.clr_cnt, cmd.clr_flags, cmd.clr_err}));
  assert_xfer_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.load_cnt, cmd.latch_cnt, cmd.load_psc}));
endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NBYTES  = 3,
  parameter int FIELD_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic                         bus_ctl,
  input  logic                         bus_axis,
  input  logic [DATA_W-1:0]            bus_din,
  output logic [DATA_W-1:0]            bus_dout,
  output logic                         bus_dout_oe,
  input  logic [2*DATA_W*NBYTES-1:0]   latch_val,
  input  logic [2*DATA_W-1:0]          status_in,
  output logic [2*DATA_W*NBYTES-1:0]   preset_val,
  output logic [2*FIELD_W-1:0]         mode_reg,
  output logic [2*FIELD_W-1:0]         io_reg,
  output logic [2*FIELD_W-1:0]         index_reg,
  output logic [1:0]                   cmd_clr_cnt,
  output logic [1:0]                   cmd_clr_flags,
  output logic [1:0]                   cmd_clr_err,
  output logic [1:0]                   cmd_load_cnt,
  output logic [1:0]                   cmd_latch_cnt,
  output logic [1:0]                   cmd_load_psc
);
  localparam int NAXES = 2;
  localparam int PRE_W = DATA_W * NBYTES;
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic              wr_done, rd_done, cap_ctl, cap_axis;
  logic [DATA_W-1:0] cap_din;
  logic [PTR_W-1:0]  ptr_w [NAXES];
  hbi_cmd_t          cmd_w [NAXES];

  hbi_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .rd(bus_rd), .wr(bus_wr),
    .ctl(bus_ctl), .axis(bus_axis), .din(bus_din),
    .wr_done(wr_done), .rd_done(rd_done), .cap_ctl(cap_ctl),
    .cap_axis(cap_axis), .cap_din(cap_din)
  );

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    logic axis_hit, ctl_hit;
    assign axis_hit = (cap_axis == a[0]);
    assign ctl_hit  = wr_done & cap_ctl & (cap_din[DATA_W-1] | axis_hit);

    hbi_axis #(.DATA_W(DATA_W), .NBYTES(NBYTES), .FIELD_W(FIELD_W)) u_axis (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_hit),
      .data_wr(wr_done & ~cap_ctl & axis_hit),
      .data_rd(rd_done & ~cap_ctl & axis_hit),
      .byte_in(cap_din),
      .preset(preset_val[a*PRE_W +: PRE_W]),
      .ptr(ptr_w[a]),
      .mode_f(mode_reg[a*FIELD_W +: FIELD_W]),
      .io_f(io_reg[a*FIELD_W +: FIELD_W]),
      .idx_f(index_reg[a*FIELD_W +: FIELD_W]),
      .cmd(cmd_w[a])
    );

    assign cmd_clr_cnt[a]   = cmd_w[a].clr_cnt;
    assign cmd_clr_flags[a] = cmd_w[a].clr_flags;
    assign cmd_clr_err[a]   = cmd_w[a].clr_err;
    assign cmd_load_cnt[a]  = cmd_w[a].load_cnt;
    assign cmd_latch_cnt[a] = cmd_w[a].latch_cnt;
    assign cmd_load_psc[a]  = cmd_w[a].load_psc;
  end

  always_comb begin
    logic [PRE_W-1:0] lat;
    lat = latch_val[(bus_axis ? PRE_W : 0) +: PRE_W];
    if (bus_ctl) bus_dout = status_in[(bus_axis ? DATA_W : 0) +: DATA_W];
    else         bus_dout = lat[ptr_w[bus_axis]*DATA_W +: DATA_W];
  end

  assign bus_dout_oe = bus_sel & bus_rd;

  // a command pulse must follow a write strobe that had already fallen
  assert_pulse_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{cmd_clr_cnt, cmd_clr_flags, cmd_clr_err, cmd_load_cnt, cmd_latch_cnt, cmd_load_psc})
      |-> !$past(bus_sel & bus_wr));
endmodule

// File: tb/hbi_top_bench.sv
module hbi_top_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_rd = 0, bus_wr = 0, bus_ctl = 0, bus_axis = 0;
  logic [7:0]  bus_din = '0, bus_dout;
  logic        bus_dout_oe;
  logic [47:0] latch_val = '0, preset_val;
  logic [15:0] status_in = '0;
  logic [9:0]  mode_reg, io_reg, index_reg;
  logic [1:0]  cmd_clr_cnt, cmd_clr_flags, cmd_clr_err, cmd_load_cnt, cmd_latch_cnt, cmd_load_psc;

  int vectors = 0, errors = 0;
  bit finished = 0;

  logic [4:0]  mode_m [2], io_m [2], idx_m [2];
  logic [1:0]  ptr_m [2];
  logic [23:0] pre_m [2];

  always #(PERIOD/2) clk = ~clk;

  hbi_top u_hbi_top (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic sel, input logic ctl, input logic ax, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1; bus_ctl = ctl; bus_axis = ax; bus_din = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic do_rd(input logic ctl, input logic ax, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_ctl = ctl; bus_axis = ax;
    #1 d = bus_dout;
    chk("R11 oe during read", {63'd0, bus_dout_oe}, 64'd1);
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    @(negedge clk);
  endtask

  function automatic logic [5:0] exp_cmd(input logic [7:0] v);
    exp_cmd = {v[2:1] == 2'd1, v[2:1] == 2'd2, v[2:1] == 2'd3,
               v[4:3] == 2'd1, v[4:3] == 2'd2, v[4:3] == 2'd3};
  endfunction

  task automatic check_regs(input string tag);
    for (int a = 0; a < 2; a++) begin
      chk({tag, " mode"},   mode_reg[a*5 +: 5],  mode_m[a]);
      chk({tag, " io"},     io_reg[a*5 +: 5],    io_m[a]);
      chk({tag, " index"},  index_reg[a*5 +: 5], idx_m[a]);
      chk({tag, " preset"}, preset_val[a*24 +: 24], pre_m[a]);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    for (int a = 0; a < 2; a++) begin
      mode_m[a] = 0; io_m[a] = 0; idx_m[a] = 0; ptr_m[a] = 0; pre_m[a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check_regs("R12 reset");
    chk("R12 no pulses", {cmd_clr_cnt, cmd_clr_flags, cmd_clr_err, cmd_load_cnt, cmd_latch_cnt, cmd_load_psc}, 0);

    // R2 R3 R8 R9 R10: every control byte on both axis selects
    for (int ax = 0; ax < 2; ax++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        b = v[7:0];
        do_wr(1, 1, ax[0], b);
        for (int a = 0; a < 2; a++) begin
          bit hit;
          logic [5:0] act;
          hit = b[7] || (a == ax);
          act = {cmd_clr_cnt[a], cmd_clr_flags[a], cmd_clr_err[a],
                 cmd_load_cnt[a], cmd_latch_cnt[a], cmd_load_psc[a]};
          chk("R9 R10 R3 pulse", act, (hit && b[6:5] == 2'd0) ? exp_cmd(b) : 6'd0);
          if (hit) begin
            case (b[6:5])
              2'd0: if (b[0]) ptr_m[a] = 0;
              2'd1: mode_m[a] = b[4:0];
              2'd2: io_m[a]   = b[4:0];
              default: idx_m[a] = b[4:0];
            endcase
          end
        end
        check_regs("R2 R3 control");
        @(negedge clk);
        chk("R9 pulse one cycle", {cmd_clr_cnt, cmd_clr_flags, cmd_clr_err, cmd_load_cnt, cmd_latch_cnt, cmd_load_psc}, 0);
      end
    end

    // R4 R7: data writes with wrap, both axes
    for (int ax = 0; ax < 2; ax++) begin
      for (int k = 0; k < 7; k++) begin
        logic [7:0] d;
        d = 8'(8'h31 * (k + 1) + ax * 8'h4C);
        do_wr(1, 0, ax[0], d);
        pre_m[ax][ptr_m[ax]*8 +: 8] = d;
        ptr_m[ax] = (ptr_m[ax] == 2) ? 2'd0 : ptr_m[ax] + 2'd1;
        check_regs("R4 R7 data write");
      end
    end

    // R5 R7: data reads with wrap
    latch_val = 48'hA1B2C3_D4E5F6;
    for (int ax = 0; ax < 2; ax++) begin
      for (int k = 0; k < 5; k++) begin
        do_rd(0, ax[0], rb);
        chk("R5 R7 latch byte", rb, latch_val[ax*24 + ptr_m[ax]*8 +: 8]);
        ptr_m[ax] = (ptr_m[ax] == 2) ? 2'd0 : ptr_m[ax] + 2'd1;
      end
    end

    // R6: status reads leave pointer alone
    status_in = 16'h5AC3;
    for (int ax = 0; ax < 2; ax++) begin
      do_rd(1, ax[0], rb);
      chk("R6 status byte", rb, status_in[ax*8 +: 8]);
      do_rd(0, ax[0], rb);
      chk("R6 pointer unmoved", rb, latch_val[ax*24 + ptr_m[ax]*8 +: 8]);
      ptr_m[ax] = (ptr_m[ax] == 2) ? 2'd0 : ptr_m[ax] + 2'd1;
    end

    // R8: pointer clear for X only, then broadcast
    do_wr(1, 0, 0, 8'h11); pre_m[0][ptr_m[0]*8 +: 8] = 8'h11; ptr_m[0] = (ptr_m[0] == 2) ? 2'd0 : ptr_m[0] + 2'd1;
    do_wr(1, 0, 1, 8'h22); pre_m[1][ptr_m[1]*8 +: 8] = 8'h22; ptr_m[1] = (ptr_m[1] == 2) ? 2'd0 : ptr_m[1] + 2'd1;
    do_wr(1, 1, 0, 8'h01); ptr_m[0] = 0;
    for (int ax = 0; ax < 2; ax++) begin
      do_rd(0, ax[0], rb);
      chk("R8 axis clear", rb, latch_val[ax*24 + ptr_m[ax]*8 +: 8]);
      ptr_m[ax] = (ptr_m[ax] == 2) ? 2'd0 : ptr_m[ax] + 2'd1;
    end
    do_wr(1, 1, 0, 8'h81); ptr_m[0] = 0; ptr_m[1] = 0;
    for (int ax = 0; ax < 2; ax++) begin
      do_rd(0, ax[0], rb);
      chk("R8 broadcast clear", rb, latch_val[ax*24 +: 8]);
      ptr_m[ax] = 1;
    end

    // R1: deselected strobes do nothing
    do_wr(0, 1, 0, 8'hBF);
    chk("R1 no pulse", {cmd_clr_cnt, cmd_clr_flags, cmd_clr_err, cmd_load_cnt, cmd_latch_cnt, cmd_load_psc}, 0);
    do_wr(0, 1, 1, 8'h3B);
    chk("R1 no pulse", {cmd_clr_cnt, cmd_clr_flags, cmd_clr_err, cmd_load_cnt, cmd_latch_cnt, cmd_load_psc}, 0);
    do_wr(0, 0, 0, 8'hEE);
    do_wr(0, 0, 1, 8'hDD);
    check_regs("R1 deselected write");
    @(negedge clk);
    bus_rd = 1; bus_ctl = 0; bus_axis = 0;
    #1 chk("R1 R11 oe low unselected", {63'd0, bus_dout_oe}, 0);
    @(negedge clk);
    bus_rd = 0;
    @(negedge clk);
    for (int ax = 0; ax < 2; ax++) begin
      do_rd(0, ax[0], rb);
      chk("R1 pointer unmoved", rb, latch_val[ax*24 + ptr_m[ax]*8 +: 8]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule